// File: doc/BRIEF.md
# Four-Beat Accumulator Processor Core

This block is a small stored-program processor with a parallel datapath. It keeps the instruction timing of an early valve-era machine. Every instruction passes through the same four beats: two scan beats and two action beats, in alternation. A slow beat strobe, one pulse for each beat, drives the sequence. In a full system that strobe comes from a divider that makes 360 us beats, each with a 320 us active part and a 40 us blanking part. Inside the block it is only an input, so the beat length is whatever the strobe source chooses.

The core holds an accumulator, a program counter, a present-instruction register that keeps the decoded fields of the fetched word, and two latches: one for the operand address and one for the function code. Its working store is a dual-port RAM. The core uses one port. The other port is brought out unchanged, so a display or loader can read or write the store at any time. When the run input is low, or after a halt, the beats keep cycling and the fetches keep happening, but the accumulator, the program counter and the store do not change. A manual-reset input returns the machine to its start state without touching the store.

Top module: `beat_cpu`

## Requirements
- R1: After rst_ni is asserted, or after a clock edge with man_rst_i high, pc_o and acc_o are 0, beat_o is 0 and halted_o is 0. The store contents are kept.
- R2: beat_o steps 0 (first scan), 1 (first action), 2 (second scan), 3 (second action), then back to 0, one step for each clock with beat_stb_i high. Without a strobe, beat_o and all machine state hold.
- R3: Only two fields of an instruction word are decoded: the operand address S in bits [ADDR_W-1:0] and the function code in bits [FN_LSB+2:FN_LSB]. All other bits are ignored.
- R4: On the first-scan strobe the program counter increments, modulo 2^DATA_W. On the first-action strobe the word at store[pc mod 2^ADDR_W] is fetched. After a reset, the first instruction therefore executes from address 1.
- R5: Function 010 loads the two's-complement negation of store[S] into the accumulator.
- R6: Functions 100 and 101 both subtract store[S] from the accumulator, modulo 2^DATA_W.
- R7: Function 011 writes the accumulator to store[S]. The second port reads the new value.
- R8: Function 000 loads store[S] into the program counter. The next fetch is then from store[S]+1.
- R9: Function 001 adds store[S] to the program counter. The program counter still holds the address of the jump word when the addition happens.
- R10: Function 110 increments the program counter once more, which skips the next word, when the accumulator's top bit is 1. It does nothing otherwise.
- R11: Function 111 sets halted_o. While halted, the beats continue, but pc_o, acc_o and the store do not change until a manual reset.
- R12: While run_i is 0, the beats and fetches continue, but pc_o, acc_o and the store do not change.
- R13: The second store port reads combinationally and writes on the clock edge, independently of the core. If both ports write the same address in the same cycle, the core's write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_stb_i | input | 1 | One-cycle pulse that ends the current beat |
| run_i | input | 1 | 1 = run, 0 = stop (beats continue, no commits) |
| man_rst_i | input | 1 | Synchronous manual reset of the machine state |
| aux_addr_i | input | ADDR_W | Second-port store address |
| aux_we_i | input | 1 | Second-port write enable |
| aux_wdata_i | input | DATA_W | Second-port write data |
| aux_rdata_o | output | DATA_W | Second-port read data (combinational) |
| beat_o | output | 2 | Current beat, 0..3 |
| acc_o | output | DATA_W | Accumulator |
| pc_o | output | DATA_W | Program counter |
| halted_o | output | 1 | Halt instruction has executed |

## Verification
The bench builds the core with DATA_W=16, ADDR_W=4 and FN_LSB=13, which gives a 16-word store whose function code sits in the top three bits. With this size, negative and positive operands, wrap of the subtraction and the sign bit used by the skip test all fall within short sweeps that the bench predicts arithmetically. Junk in the undecoded bits 12:4 can be tested directly. Each function code, including both subtract encodings, is swept over several operand values. Every case goes through the second port, with a manual reset before each program.

// File: rtl/beat_cpu_pkg.sv
package beat_cpu_pkg;
  typedef enum logic [1:0] {
    BT_SCAN1 = 2'd0,
    BT_ACT1  = 2'd1,
    BT_SCAN2 = 2'd2,
    BT_ACT2  = 2'd3
  } beat_e;

  typedef enum logic [2:0] {
    FN_JMP  = 3'd0,
    FN_JRP  = 3'd1,
    FN_LDN  = 3'd2,
    FN_STO  = 3'd3,
    FN_SUB  = 3'd4,
    FN_SUB2 = 3'd5,
    FN_CMP  = 3'd6,
    FN_STP  = 3'd7
  } fn_e;

  localparam int unsigned FN_W = 3;
endpackage

// File: rtl/beat_seq.sv
module beat_seq
  import beat_cpu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stb_i,
  input  logic  clr_i,
  output beat_e beat_o
);
  beat_e beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beat_q <= BT_SCAN1;
    else if (clr_i) beat_q <= BT_SCAN1;
    else if (stb_i) beat_q <= beat_e'(beat_q + 2'd1);
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/beat_store.sv
module beat_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit_a, hit_b;
    assign hit_a = a_we_i && (a_addr_i == ADDR_W'(w));
    assign hit_b = b_we_i && (b_addr_i == ADDR_W'(w));
    // core port has priority on a same-word collision
    always_ff @(posedge clk_i) begin
      if (hit_a)      mem[w] <= a_wdata_i;
      else if (hit_b) mem[w] <= b_wdata_i;
    end
  end

  assign a_rdata_o = mem[a_addr_i];
  assign b_rdata_o = mem[b_addr_i];
endmodule

// File: rtl/beat_exec.sv
module beat_exec
  import beat_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned FN_LSB = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  beat_e             beat_i,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              halted_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] acc_q, pc_q;
  logic [ADDR_W-1:0] pi_addr_q, s_lat_q;
  fn_e               pi_fn_q, f_lat_q;
  logic              halt_q;
  logic              commit;

  assign commit = run_i && !halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      pc_q      <= '0;
      pi_addr_q <= '0;
      pi_fn_q   <= FN_JMP;
      s_lat_q   <= '0;
      f_lat_q   <= FN_JMP;
      halt_q    <= 1'b0;
    end else if (clr_i) begin
      acc_q     <= '0;
      pc_q      <= '0;
      pi_addr_q <= '0;
      pi_fn_q   <= FN_JMP;
      s_lat_q   <= '0;
      f_lat_q   <= FN_JMP;
      halt_q    <= 1'b0;
    end else if (stb_i) begin
      unique case (beat_i)
        BT_SCAN1: if (commit) pc_q <= pc_q + ONE;
        BT_ACT1: begin
          pi_addr_q <= rdata_i[ADDR_W-1:0];
          pi_fn_q   <= fn_e'(rdata_i[FN_LSB +: FN_W]);
        end
        BT_SCAN2: begin
          s_lat_q <= pi_addr_q;
          f_lat_q <= pi_fn_q;
        end
        BT_ACT2: if (commit) begin
          unique case (f_lat_q)
            FN_JMP:          pc_q   <= rdata_i;
            FN_JRP:          pc_q   <= pc_q + rdata_i;
            FN_LDN:          acc_q  <= '0 - rdata_i;
            FN_STO:          ;
            FN_SUB, FN_SUB2: acc_q  <= acc_q - rdata_i;
            FN_CMP:          if (acc_q[DATA_W-1]) pc_q <= pc_q + ONE;
            FN_STP:          halt_q <= 1'b1;
          endcase
        end
      endcase
    end
  end

  // fetch addresses via the pc, every other beat via the address latch
  assign addr_o   = (beat_i == BT_ACT1) ? pc_q[ADDR_W-1:0] : s_lat_q;
  assign we_o     = stb_i && !clr_i && commit && (beat_i == BT_ACT2) && (f_lat_q == FN_STO);
  assign wdata_o  = acc_q;
  assign acc_o    = acc_q;
  assign pc_o     = pc_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/beat_cpu.sv
module beat_cpu
  import beat_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned FN_LSB = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_stb_i,
  input  logic              run_i,
  input  logic              man_rst_i,
  input  logic [ADDR_W-1:0] aux_addr_i,
  input  logic              aux_we_i,
  input  logic [DATA_W-1:0] aux_wdata_i,
  output logic [DATA_W-1:0] aux_rdata_o,
  output logic [1:0]        beat_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              halted_o
);
  beat_e             beat;
  logic [ADDR_W-1:0] core_addr;
  logic              core_we;
  logic [DATA_W-1:0] core_wdata, core_rdata;

  beat_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (beat_stb_i),
    .clr_i  (man_rst_i),
    .beat_o (beat)
  );

  beat_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FN_LSB(FN_LSB)) u_exec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (beat_stb_i),
    .beat_i   (beat),
    .run_i    (run_i),
    .clr_i    (man_rst_i),
    .rdata_i  (core_rdata),
    .addr_o   (core_addr),
    .we_o     (core_we),
    .wdata_o  (core_wdata),
    .acc_o    (acc_o),
    .pc_o     (pc_o),
    .halted_o (halted_o)
  );

  beat_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .a_addr_i  (core_addr),
    .a_we_i    (core_we),
    .a_wdata_i (core_wdata),
    .a_rdata_o (core_rdata),
    .b_addr_i  (aux_addr_i),
    .b_we_i    (aux_we_i),
    .b_wdata_i (aux_wdata_i),
    .b_rdata_o (aux_rdata_o)
  );

  assign beat_o = beat;
endmodule

// File: rtl/beat_cpu_chk.sv
module beat_cpu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_stb_i,
  input logic              run_i,
  input logic              man_rst_i,
  input logic [1:0]        beat_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              halted_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assert_man_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> (pc_o == '0) && (acc_o == '0) && (beat_o == 2'd0) && !halted_o);

  assert_beat_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_stb_i && !man_rst_i) |=> beat_o == $past(beat_o) + 2'd1);

  assert_beat_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_stb_i && !man_rst_i) |=>
      $stable(beat_o) && $stable(pc_o) && $stable(acc_o) && $stable(halted_o));

  assert_pc_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_stb_i && beat_o == 2'd0 && run_i && !halted_o && !man_rst_i) |=>
      pc_o == $past(pc_o) + ONE);

  // R5/R6: accumulator only moves on the second action beat
  assert_acc_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(beat_stb_i && beat_o == 2'd3) && !man_rst_i) |=> $stable(acc_o));

  assert_halt_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !man_rst_i) |=> halted_o && $stable(pc_o) && $stable(acc_o));

  assert_stop_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !man_rst_i) |=> $stable(pc_o) && $stable(acc_o));
endmodule

bind beat_cpu beat_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .beat_stb_i (beat_stb_i),
  .run_i      (run_i),
  .man_rst_i  (man_rst_i),
  .beat_o     (beat_o),
  .acc_o      (acc_o),
  .pc_o       (pc_o),
  .halted_o   (halted_o)
);

// File: tb/beat_cpu_tb.sv
module beat_cpu_tb;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int FL = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0, run = 1'b1, mrst = 1'b0;
  logic [AW-1:0] aux_addr = '0;
  logic          aux_we = 1'b0;
  logic [DW-1:0] aux_wdata = '0;
  logic [DW-1:0] aux_rdata, acc, pc;
  logic [1:0]    beat;
  logic          halted;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  beat_cpu #(.DATA_W(DW), .ADDR_W(AW), .FN_LSB(FL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .beat_stb_i(stb), .run_i(run), .man_rst_i(mrst),
    .aux_addr_i(aux_addr), .aux_we_i(aux_we), .aux_wdata_i(aux_wdata),
    .aux_rdata_o(aux_rdata), .beat_o(beat), .acc_o(acc), .pc_o(pc), .halted_o(halted)
  );

  function automatic logic [DW-1:0] mk(int fn, int a);
    return DW'((fn << FL) | a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
  endtask

  task automatic instr(int n);
    repeat (n * 4) step();
  endtask

  task automatic poke(int a, logic [DW-1:0] d);
    @(negedge clk);
    aux_we = 1'b1; aux_addr = AW'(a); aux_wdata = d;
    @(negedge clk) aux_we = 1'b0;
  endtask

  task automatic peek(int a, output logic [DW-1:0] d);
    aux_addr = AW'(a);
    #1 d = aux_rdata;
  endtask

  task automatic man_reset();
    @(negedge clk) mrst = 1'b1;
    @(negedge clk) mrst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, w, rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, 0); chk("R1 acc", acc, 0);
    chk("R1 beat", beat, 0); chk("R1 halted", halted, 0);
    for (int a = 0; a < 16; a++) poke(a, '0);

    // R2 beat order, stop mode so nothing else moves
    run = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R2 beat order", beat, k % 4);
      step();
    end
    step();
    repeat (5) @(negedge clk);
    chk("R2 hold without strobe", beat, 1);
    man_reset();
    run = 1'b1;

    // R13 second port write/read
    poke(7, 16'hA5C3);
    peek(7, rd);
    chk("R13 aux rw", rd, 16'hA5C3);

    // R5 / R4 negating load sweep
    for (int i = 0; i < 16; i++) begin
      v = DW'(i * 4369 + (i << 12) + 3);
      poke(1, mk(2, 9)); poke(9, v);
      man_reset();
      instr(1);
      chk("R5 ldn acc", acc, DW'(-v));
      chk("R4 pc after one", pc, 1);
    end

    // R3 undecoded bits 12:4 ignored
    poke(1, mk(2, 9) | 16'h1FF0); poke(9, 16'h0123);
    man_reset(); instr(1);
    chk("R3 junk bits", acc, DW'(-16'h0123));

    // R6 subtract, both encodings
    for (int i = 0; i < 16; i++) begin
      v = DW'(i * 5003 + 1); w = DW'(i * 9001 + 40000);
      poke(1, mk(2, 9)); poke(2, mk((i % 2) ? 5 : 4, 10));
      poke(9, v); poke(10, w);
      man_reset(); instr(2);
      chk("R6 sub", acc, DW'(-v - w));
    end

    // R12 stop then R7 store
    poke(1, mk(2, 9)); poke(2, mk(3, 11)); poke(9, 16'h0042); poke(11, 16'h0000);
    man_reset(); instr(1);
    run = 1'b0;
    instr(3);
    chk("R12 pc held", pc, 1);
    chk("R12 acc held", acc, DW'(-16'h0042));
    chk("R12 beat runs", beat, 0);
    peek(11, rd);
    chk("R12 store held", rd, 0);
    run = 1'b1;
    instr(1);
    peek(11, rd);
    chk("R7 sto", rd, DW'(-16'h0042));
    chk("R7 pc", pc, 2);

    // R8 absolute jump, next fetch from target+1
    foreach (v[k]) begin end
    for (int j = 0; j < 3; j++) begin
      int t;
      t = (j == 0) ? 3 : (j == 1) ? 5 : 14;
      poke(1, mk(0, 9)); poke(9, DW'(t));
      poke(t + 1, mk(2, 12)); poke(12, DW'(16'h0055 + j));
      man_reset(); instr(1);
      chk("R8 jmp pc", pc, t);
      instr(1);
      chk("R8 next fetch", acc, DW'(-(16'h0055 + j)));
      chk("R8 pc after", pc, t + 1);
    end

    // R9 relative jump
    for (int d = 2; d <= 6; d += 2) begin
      poke(1, mk(1, 9)); poke(9, DW'(d));
      man_reset(); instr(1);
      chk("R9 jrp pc", pc, 1 + d);
    end

    // R10 skip when negative
    for (int i = 0; i < 16; i++) begin
      v = (i == 0) ? 16'h0000 : (i == 1) ? 16'h8000 : DW'(i * 7777);
      w = DW'(-v);
      poke(1, mk(2, 9)); poke(2, mk(6, 0)); poke(9, v);
      man_reset(); instr(2);
      chk("R10 cmp pc", pc, w[DW-1] ? 3 : 2);
    end

    // R11 halt
    poke(1, mk(2, 9)); poke(2, mk(7, 0)); poke(3, mk(3, 9)); poke(9, 16'h0005);
    man_reset(); instr(2);
    chk("R11 halted", halted, 1);
    chk("R11 pc", pc, 2);
    instr(2);
    step();
    chk("R11 beats continue", beat, 1);
    chk("R11 pc held", pc, 2);
    chk("R11 acc held", acc, DW'(-16'h0005));
    peek(9, rd);
    chk("R11 store held", rd, 16'h0005);
    man_reset();
    chk("R1 man reset halted", halted, 0);
    chk("R1 man reset beat", beat, 0);
    chk("R1 man reset pc", pc, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule